// File: doc/BRIEF.md
# Interrupt Source Table

The block holds per-source interrupt state for a fixed set of sources whose global numbers start at a base offset. For every source it keeps a destination server, a current priority, a saved priority and a small set of status flags. A per-source type input marks each source as level-type or message-type. Source line events, reject and end-of-interrupt notifications coming back from a presentation layer, a whole-table resend command and configuration commands all update this state. Whenever a source becomes due, a delivery naming its server, global number and priority is offered on a valid/ready output port.

Priority all-ones (0xFF with the default width) means masked. Message sources that fire while masked are remembered and released when a later configuration write unmasks them. Level sources follow their input line and are offered again only after an end-of-interrupt or a reject has cleared their sent flag. Disable parks the current priority in the saved slot so that enable can bring it back.

Configuration commands return one response per command on the next cycle. Reject and end-of-interrupt notifications carry global source numbers. Line events carry the local source index.

Top module: `irq_src_table`

## Requirements
- R1: After reset every source has server 0, priority 0xFF and saved priority 0xFF, no delivery is offered and the busy flag is low.
- R2: A message source that fires while its priority is 0xFF offers no delivery. A later write, or an enable, that leaves its priority below 0xFF offers it once.
- R3: A message source that fires while its priority is below 0xFF offers a delivery carrying its server, the number base plus its local index, and its priority.
- R4: A level source tracks its line. It is offered only when its priority is below 0xFF, its line is high and it is not already sent. The sent flag is set when the handshake completes, so a repeated high event offers nothing more.
- R5: A reject naming a source clears its sent flag and marks it rejected. A following resend offers it again: a message source if its priority is below 0xFF, a level source if its line is still high.
- R6: A resend raises busy on the next cycle and keeps it high for exactly NUM_SRC cycles while it visits the sources in ascending order, one per cycle. A message source that was not rejected is not offered. A rejected message source with priority 0xFF loses its rejected mark and is not offered.
- R7: An end-of-interrupt naming a level source clears its sent flag, so a later high event offers it again. For a message source it changes nothing.
- R8: Command op codes are 0 for write, 1 for read, 2 for disable and 3 for enable. A write sets the server, priority and saved priority. A read returns the server and the priority. Disable, enable and write return zero data.
- R9: Disable sets the priority to 0xFF and copies the old priority into the saved priority. Enable copies the saved priority back. Both then reapply the delivery rule for the source's type.
- R10: A command whose number is below the base or at or above base plus NUM_SRC, or a write whose server is NUM_SERVERS or more, returns the error flag with zero data and leaves the table unchanged.
- R11: While a delivery is offered and not accepted, its number is held stable. Several due sources are offered one at a time, lowest local index first, once the held one has been taken.
- R12: The response to a command is valid exactly on the cycle after the command and on no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_level_i | input | NUM_SRC | Per-source type: 1 level, 0 message |
| ev_valid_i | input | 1 | Source line event strobe |
| ev_idx_i | input | IDX_W | Local index of the event source |
| ev_val_i | input | 1 | Line value (level) or fire (message) |
| rej_valid_i | input | 1 | Reject notification strobe |
| rej_num_i | input | NUM_W | Global number of the rejected source |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number of the completed source |
| resend_i | input | 1 | Start a resend scan |
| busy_o | output | 1 | Resend scan in progress |
| cmd_valid_i | input | 1 | Configuration command strobe |
| cmd_op_i | input | 2 | Command op code |
| cmd_num_i | input | NUM_W | Global source number of the command |
| cmd_srv_i | input | SRV_W | Server for a write |
| cmd_prio_i | input | PRIO_W | Priority for a write |
| rsp_valid_o | output | 1 | Command response valid |
| rsp_err_o | output | 1 | Parameter error |
| rsp_srv_o | output | SRV_W | Server returned by a read |
| rsp_prio_o | output | PRIO_W | Priority returned by a read |
| dlv_valid_o | output | 1 | Delivery offered |
| dlv_ready_i | input | 1 | Delivery accepted |
| dlv_srv_o | output | SRV_W | Delivery target server |
| dlv_num_o | output | NUM_W | Delivery global source number |
| dlv_prio_o | output | PRIO_W | Delivery priority |

## Verification
A wrong flag inside the table mostly stays hidden until something reads it. A stuck sent flag shows only as a missing offer on the next high event or resend. A lost masked-pending mark shows only when that source is next unmasked. A wrong stored priority is visible at once through a read, or on the next offer from that source. The checks therefore always pair the stimulus that corrupts a flag with the later event that exposes it, and they watch the delivery port for exactly one cycle-accurate offer, or for none, after each step.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_OFF   = 2'd2,
        OP_ON    = 2'd3
    } cmd_op_e;

    typedef struct packed {
        logic queued;    // delivery due, waiting for the handshake
        logic mpend;     // message fired while masked
        logic rejected;  // bounced by the presentation layer
        logic sent;      // level source handed over, awaiting completion
        logic asserted;  // level source line state
    } src_flags_t;

endpackage

// File: rtl/ist_range_chk.sv
module ist_range_chk #(
    parameter int BASE  = 16,
    parameter int COUNT = 8,
    parameter int NUM_W = 12,
    parameter int IDX_W = 3
) (
    input  logic [NUM_W-1:0] num_i,
    output logic             ok_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [NUM_W:0] LO = (NUM_W+1)'(BASE);
    localparam logic [NUM_W:0] HI = (NUM_W+1)'(BASE + COUNT);

    logic [NUM_W:0] ext;

    always_comb begin
        ext   = {1'b0, num_i};
        ok_o  = (ext >= LO) && (ext < HI);
        idx_o = IDX_W'(ext - LO);
    end
endmodule

// File: rtl/ist_pick.sv
module ist_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ist_scan.sv
module ist_scan #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (!scan_q.busy) begin
            if (start_i) begin
                scan_d.busy = 1'b1;
                scan_d.idx  = '0;
            end
        end else if (scan_q.idx == LAST) begin
            scan_d.busy = 1'b0;
        end else begin
            scan_d.idx = scan_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign busy_o = scan_q.busy;
    assign idx_o  = scan_q.idx;
endmodule

// File: rtl/irq_src_table.sv
module irq_src_table
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int SRC_BASE    = 16,
    parameter int NUM_SERVERS = 4,
    parameter int SRV_W       = 4,
    parameter int PRIO_W      = 8,
    parameter int NUM_W       = 12,
    localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_level_i,
    input  logic               ev_valid_i,
    input  logic [IDX_W-1:0]   ev_idx_i,
    input  logic               ev_val_i,
    input  logic               rej_valid_i,
    input  logic [NUM_W-1:0]   rej_num_i,
    input  logic               eoi_valid_i,
    input  logic [NUM_W-1:0]   eoi_num_i,
    input  logic               resend_i,
    output logic               busy_o,
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_op_i,
    input  logic [NUM_W-1:0]   cmd_num_i,
    input  logic [SRV_W-1:0]   cmd_srv_i,
    input  logic [PRIO_W-1:0]  cmd_prio_i,
    output logic               rsp_valid_o,
    output logic               rsp_err_o,
    output logic [SRV_W-1:0]   rsp_srv_o,
    output logic [PRIO_W-1:0]  rsp_prio_o,
    output logic               dlv_valid_o,
    input  logic               dlv_ready_i,
    output logic [SRV_W-1:0]   dlv_srv_o,
    output logic [NUM_W-1:0]   dlv_num_o,
    output logic [PRIO_W-1:0]  dlv_prio_o
);
    localparam logic [PRIO_W-1:0] MASKED = '1;

    typedef struct packed {
        logic [SRV_W-1:0]  srv;
        logic [PRIO_W-1:0] prio;
        logic [PRIO_W-1:0] saved;
        src_flags_t        fl;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_SRC-1:0] tbl;
        logic                 hold_v;
        logic [IDX_W-1:0]     hold_idx;
        logic                 rsp_v;
        logic                 rsp_err;
        logic [SRV_W-1:0]     rsp_srv;
        logic [PRIO_W-1:0]    rsp_prio;
    } state_t;

    state_t st_d, st_q;
    entry_t ent;

    // ---- per-type rules --------------------------------------------------
    function automatic entry_t level_rule(entry_t e);
        entry_t r = e;
        if ((e.prio != MASKED) && e.fl.asserted && !e.fl.sent) begin
            r.fl.queued = 1'b1;
        end
        return r;
    endfunction

    function automatic entry_t after_config(entry_t e, logic is_lvl);
        entry_t r = e;
        if (is_lvl) begin
            r = level_rule(e);
        end else if (e.fl.mpend && (e.prio != MASKED)) begin
            r.fl.mpend  = 1'b0;
            r.fl.queued = 1'b1;
        end
        return r;
    endfunction

    function automatic entry_t msg_resend(entry_t e);
        entry_t r = e;
        if (e.fl.rejected) begin
            r.fl.rejected = 1'b0;
            if (e.prio != MASKED) begin
                r.fl.queued = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic state_t reset_state();
        state_t s = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            s.tbl[i].prio  = MASKED;
            s.tbl[i].saved = MASKED;
        end
        return s;
    endfunction

    // ---- number decode ---------------------------------------------------
    logic             cmd_ok, rej_ok, eoi_ok;
    logic [IDX_W-1:0] cmd_idx, rej_idx, eoi_idx;

    ist_range_chk #(.BASE(SRC_BASE), .COUNT(NUM_SRC), .NUM_W(NUM_W), .IDX_W(IDX_W))
        u_cmd_rng (.num_i(cmd_num_i), .ok_o(cmd_ok), .idx_o(cmd_idx));
    ist_range_chk #(.BASE(SRC_BASE), .COUNT(NUM_SRC), .NUM_W(NUM_W), .IDX_W(IDX_W))
        u_rej_rng (.num_i(rej_num_i), .ok_o(rej_ok), .idx_o(rej_idx));
    ist_range_chk #(.BASE(SRC_BASE), .COUNT(NUM_SRC), .NUM_W(NUM_W), .IDX_W(IDX_W))
        u_eoi_rng (.num_i(eoi_num_i), .ok_o(eoi_ok), .idx_o(eoi_idx));

    // ---- delivery selection ----------------------------------------------
    logic [NUM_SRC-1:0] queued_vec;
    logic               arb_any;
    logic [IDX_W-1:0]   arb_idx, cur_idx;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            queued_vec[i] = st_q.tbl[i].fl.queued;
        end
    end

    ist_pick #(.N(NUM_SRC), .IDX_W(IDX_W))
        u_pick (.req_i(queued_vec), .any_o(arb_any), .idx_o(arb_idx));

    assign cur_idx = st_q.hold_v ? st_q.hold_idx : arb_idx;

    // ---- resend scanner --------------------------------------------------
    logic             scan_busy;
    logic [IDX_W-1:0] scan_idx;

    ist_scan #(.N(NUM_SRC), .IDX_W(IDX_W))
        u_scan (.clk_i(clk_i), .rst_ni(rst_ni), .start_i(resend_i),
                .busy_o(scan_busy), .idx_o(scan_idx));

    logic srv_ok, ev_ok;
    assign srv_ok = int'(cmd_srv_i) < NUM_SERVERS;
    assign ev_ok  = int'(ev_idx_i) < NUM_SRC;

    // ---- next state: updates applied in a fixed order ---------------------
    always_comb begin
        st_d          = st_q;
        ent           = '0;
        st_d.rsp_v    = 1'b0;
        st_d.rsp_err  = 1'b0;
        st_d.rsp_srv  = '0;
        st_d.rsp_prio = '0;

        // 1. handshake completion
        st_d.hold_v   = arb_any && !dlv_ready_i;
        st_d.hold_idx = cur_idx;
        if (arb_any && dlv_ready_i) begin
            st_d.tbl[cur_idx].fl.queued = 1'b0;
            if (src_level_i[cur_idx]) begin
                st_d.tbl[cur_idx].fl.sent = 1'b1;
            end
        end

        // 2. reject
        if (rej_valid_i && rej_ok) begin
            st_d.tbl[rej_idx].fl.rejected = 1'b1;
            st_d.tbl[rej_idx].fl.sent     = 1'b0;
        end

        // 3. end of interrupt
        if (eoi_valid_i && eoi_ok && src_level_i[eoi_idx]) begin
            st_d.tbl[eoi_idx].fl.sent = 1'b0;
        end

        // 4. configuration command
        if (cmd_valid_i) begin
            st_d.rsp_v = 1'b1;
            ent        = st_d.tbl[cmd_idx];
            unique case (cmd_op_e'(cmd_op_i))
                OP_WRITE: begin
                    if (cmd_ok && srv_ok) begin
                        ent.srv   = cmd_srv_i;
                        ent.prio  = cmd_prio_i;
                        ent.saved = cmd_prio_i;
                        st_d.tbl[cmd_idx] = after_config(ent, src_level_i[cmd_idx]);
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                end
                OP_READ: begin
                    if (cmd_ok) begin
                        st_d.rsp_srv  = st_q.tbl[cmd_idx].srv;
                        st_d.rsp_prio = st_q.tbl[cmd_idx].prio;
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                end
                OP_OFF: begin
                    if (cmd_ok) begin
                        ent.saved = ent.prio;
                        ent.prio  = MASKED;
                        st_d.tbl[cmd_idx] = after_config(ent, src_level_i[cmd_idx]);
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                end
                OP_ON: begin
                    if (cmd_ok) begin
                        ent.prio = ent.saved;
                        st_d.tbl[cmd_idx] = after_config(ent, src_level_i[cmd_idx]);
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                end
                default: st_d.rsp_err = 1'b1;
            endcase
        end

        // 5. source line event
        if (ev_valid_i && ev_ok) begin
            ent = st_d.tbl[ev_idx_i];
            if (src_level_i[ev_idx_i]) begin
                ent.fl.asserted = ev_val_i;
                ent             = level_rule(ent);
            end else if (ev_val_i) begin
                if (ent.prio == MASKED) begin
                    ent.fl.mpend = 1'b1;
                end else begin
                    ent.fl.queued = 1'b1;
                end
            end
            st_d.tbl[ev_idx_i] = ent;
        end

        // 6. resend scan step
        if (scan_busy) begin
            ent = st_d.tbl[scan_idx];
            if (src_level_i[scan_idx]) begin
                st_d.tbl[scan_idx] = level_rule(ent);
            end else begin
                st_d.tbl[scan_idx] = msg_resend(ent);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    // ---- outputs -----------------------------------------------------------
    assign busy_o      = scan_busy;
    assign rsp_valid_o = st_q.rsp_v;
    assign rsp_err_o   = st_q.rsp_err;
    assign rsp_srv_o   = st_q.rsp_srv;
    assign rsp_prio_o  = st_q.rsp_prio;
    assign dlv_valid_o = arb_any;
    assign dlv_srv_o   = st_q.tbl[cur_idx].srv;
    assign dlv_prio_o  = st_q.tbl[cur_idx].prio;
    assign dlv_num_o   = NUM_W'(SRC_BASE) + NUM_W'(cur_idx);
endmodule

// File: rtl/ist_checker.sv
module ist_checker #(
    parameter int NUM_SRC  = 8,
    parameter int SRC_BASE = 16,
    parameter int NUM_W    = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             resend_i,
    input logic             busy_o,
    input logic             cmd_valid_i,
    input logic             rsp_valid_o,
    input logic             dlv_valid_o,
    input logic             dlv_ready_i,
    input logic [NUM_W-1:0] dlv_num_o
);
    int unsigned busy_run;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_run <= 0;
        end else if (busy_o) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dlv_valid_o && !dlv_ready_i |=> dlv_valid_o && $stable(dlv_num_o));

    // R12
    rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_i |=> rsp_valid_o);

    // R12
    rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_valid_i |=> !rsp_valid_o);

    // R6
    scan_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resend_i && !busy_o |=> busy_o);

    // R6
    scan_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> busy_run < NUM_SRC);

    // R3
    num_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dlv_valid_o |-> (int'(dlv_num_o) >= SRC_BASE) && (int'(dlv_num_o) < SRC_BASE + NUM_SRC));
endmodule

bind irq_src_table ist_checker #(
    .NUM_SRC (NUM_SRC),
    .SRC_BASE(SRC_BASE),
    .NUM_W   (NUM_W)
) u_ist_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .resend_i   (resend_i),
    .busy_o     (busy_o),
    .cmd_valid_i(cmd_valid_i),
    .rsp_valid_o(rsp_valid_o),
    .dlv_valid_o(dlv_valid_o),
    .dlv_ready_i(dlv_ready_i),
    .dlv_num_o  (dlv_num_o)
);

// File: tb/test_irq_src_table.sv
module test_irq_src_table;
    import irq_src_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 8;
    localparam int BASE  = 16;
    localparam int NSRV  = 4;
    localparam int MASK  = 255;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_level = 8'hF0;
    logic             ev_valid = 1'b0;
    logic [2:0]       ev_idx = '0;
    logic             ev_val = 1'b0;
    logic             rej_valid = 1'b0;
    logic [11:0]      rej_num = '0;
    logic             eoi_valid = 1'b0;
    logic [11:0]      eoi_num = '0;
    logic             resend = 1'b0;
    logic             busy;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = '0;
    logic [11:0]      cmd_num = '0;
    logic [3:0]       cmd_srv = '0;
    logic [7:0]       cmd_prio = '0;
    logic             rsp_valid, rsp_err;
    logic [3:0]       rsp_srv;
    logic [7:0]       rsp_prio;
    logic             dlv_valid;
    logic             dlv_ready = 1'b0;
    logic [3:0]       dlv_srv;
    logic [11:0]      dlv_num;
    logic [7:0]       dlv_prio;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_src_table i_irq_src_table (
        .clk_i(clk), .rst_ni(rst_n), .src_level_i(src_level),
        .ev_valid_i(ev_valid), .ev_idx_i(ev_idx), .ev_val_i(ev_val),
        .rej_valid_i(rej_valid), .rej_num_i(rej_num),
        .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num),
        .resend_i(resend), .busy_o(busy),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_num_i(cmd_num),
        .cmd_srv_i(cmd_srv), .cmd_prio_i(cmd_prio),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
        .rsp_srv_o(rsp_srv), .rsp_prio_o(rsp_prio),
        .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready),
        .dlv_srv_o(dlv_srv), .dlv_num_o(dlv_num), .dlv_prio_o(dlv_prio)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic cmd(logic [1:0] op, int num, int srv, int prio);
        cmd_valid = 1'b1; cmd_op = op; cmd_num = 12'(num);
        cmd_srv = 4'(srv); cmd_prio = 8'(prio);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic event_in(int idx, bit val);
        ev_valid = 1'b1; ev_idx = 3'(idx); ev_val = val;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic reject(int num);
        rej_valid = 1'b1; rej_num = 12'(num);
        @(negedge clk);
        rej_valid = 1'b0;
    endtask

    task automatic eoi(int num);
        eoi_valid = 1'b1; eoi_num = 12'(num);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic do_resend(string req);
        int cnt = 0;
        resend = 1'b1;
        @(negedge clk);
        resend = 1'b0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(req, "busy cycles", cnt, NSRC);
    endtask

    task automatic expect_dlv(string req, int num, int srv, int prio);
        check(req, "dlv valid", int'(dlv_valid), 1);
        check(req, "dlv num", int'(dlv_num), num);
        check(req, "dlv srv", int'(dlv_srv), srv);
        check(req, "dlv prio", int'(dlv_prio), prio);
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic expect_none(string req);
        check(req, "no dlv", int'(dlv_valid), 0);
    endtask

    task automatic expect_read(string req, int num, int srv, int prio);
        cmd(OP_READ, num, 0, 0);
        check(req, "rsp valid", int'(rsp_valid), 1);
        check(req, "rsp err", int'(rsp_err), 0);
        check(req, "rsp srv", int'(rsp_srv), srv);
        check(req, "rsp prio", int'(rsp_prio), prio);
    endtask

    task automatic expect_err(string req);
        check(req, "rsp valid", int'(rsp_valid), 1);
        check(req, "rsp err", int'(rsp_err), 1);
        check(req, "rsp data", int'(rsp_srv) + int'(rsp_prio), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of every entry
        expect_none("R1");
        check("R1", "busy", int'(busy), 0);
        for (int i = 0; i < NSRC; i++) expect_read("R1", BASE + i, 0, MASK);

        // R12 response is a single-cycle pulse
        @(negedge clk);
        check("R12", "rsp idle", int'(rsp_valid), 0);

        // R10 range and server checks
        cmd(OP_READ, BASE - 1, 0, 0);           expect_err("R10");
        cmd(OP_OFF, BASE + NSRC, 0, 0);         expect_err("R10");
        cmd(OP_WRITE, BASE + NSRC, 1, 3);       expect_err("R10");
        cmd(OP_WRITE, BASE, NSRV + 1, 3);       expect_err("R10");
        expect_read("R10", BASE, 0, MASK);

        // R2 message fired while masked is held, released by the write
        event_in(0, 1'b1);
        expect_none("R2");
        for (int i = 0; i < NSRC; i++) begin
            cmd(OP_WRITE, BASE + i, i % NSRV, BASE + i);
            check("R8", "write ok", int'(rsp_err), 0);
            check("R8", "write data", int'(rsp_srv) + int'(rsp_prio), 0);
            if (i == 0) expect_dlv("R2", BASE, 0, BASE);
            else expect_none("R2");
        end
        // R8 read back the sweep
        for (int i = 0; i < NSRC; i++) expect_read("R8", BASE + i, i % NSRV, BASE + i);

        // R3 every message source delivers at once
        for (int i = 0; i < NSRC / 2; i++) begin
            event_in(i, 1'b1);
            expect_dlv("R3", BASE + i, i % NSRV, BASE + i);
        end
        expect_none("R3");

        // R11 held offer, then ascending order
        event_in(2, 1'b1);
        event_in(0, 1'b1);
        event_in(1, 1'b1);
        for (int k = 0; k < 3; k++) begin
            check("R11", "held num", int'(dlv_num), BASE + 2);
            @(negedge clk);
        end
        expect_dlv("R11", BASE + 2, 2, BASE + 2);
        expect_dlv("R11", BASE + 0, 0, BASE + 0);
        expect_dlv("R11", BASE + 1, 1, BASE + 1);
        expect_none("R11");

        // R4 level source 4
        event_in(4, 1'b1);
        expect_dlv("R4", BASE + 4, 0, BASE + 4);
        event_in(4, 1'b1);
        expect_none("R4");
        event_in(4, 1'b0);
        event_in(4, 1'b1);
        expect_none("R4");
        // R7 completion on a level source re-arms it
        eoi(BASE + 4);
        expect_none("R7");
        event_in(4, 1'b1);
        expect_dlv("R7", BASE + 4, 0, BASE + 4);

        // R7 completion on a message source changes nothing
        eoi(BASE + 0);
        do_resend("R6");
        expect_none("R7");

        // R5 rejects then resend, delivered in scan order
        event_in(5, 1'b1);
        expect_dlv("R4", BASE + 5, 1, BASE + 5);
        reject(BASE + 1);
        reject(BASE + 5);
        expect_none("R5");
        do_resend("R6");
        expect_dlv("R5", BASE + 1, 1, BASE + 1);
        expect_dlv("R5", BASE + 5, 1, BASE + 5);
        expect_none("R5");

        // R6 rejected message that is masked loses its mark silently
        cmd(OP_OFF, BASE + 3, 0, 0);
        check("R9", "off ok", int'(rsp_err), 0);
        expect_read("R9", BASE + 3, 3, MASK);
        reject(BASE + 3);
        do_resend("R6");
        expect_none("R6");
        cmd(OP_ON, BASE + 3, 0, 0);
        expect_read("R9", BASE + 3, 3, BASE + 3);
        expect_none("R6");

        // R9 disable holds a message fire, enable releases it
        cmd(OP_OFF, BASE + 3, 0, 0);
        event_in(3, 1'b1);
        expect_none("R2");
        cmd(OP_ON, BASE + 3, 0, 0);
        expect_dlv("R9", BASE + 3, 3, BASE + 3);

        // R9 level source: enable reapplies the level rule
        cmd(OP_OFF, BASE + 4, 0, 0);
        eoi(BASE + 4);
        expect_none("R9");
        cmd(OP_ON, BASE + 4, 0, 0);
        expect_dlv("R9", BASE + 4, 0, BASE + 4);
        expect_none("R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule